// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a slave on a two-wire SMBus/I2C bus that lets a host read and change a bank of fifteen 8-bit control registers for a clock generator. It takes SCL and SDA already synchronized to its own clock. It drives SDA open-drain style through a single pull-low enable. Every register's current value is available on a flat parallel output, and each accepted data byte pulses a one-cycle write strobe for its register.

A command byte follows the device address. When its top bit is set, the lower seven bits select one register for a single byte access. When its top bit is clear, the transfer is a block access. A block write carries a count byte, then data filling registers from index 0 upward. A block read returns the register count first, then register contents from index 0 upward. Some bits are read-only: five strap bits come from an input pin, and one register holds a fixed identification value. All registers come up at defined values, so the clock generator works with no bus traffic at all.

Top module: `smbc_reg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 69h (write byte D2h, read byte D3h). Any other address gets no acknowledge, and the rest of that transfer changes nothing.
- R2: A command byte with bit 7 = 1 selects the register given by bits 6:0. The next data byte is stored there and acknowledged, and the matching bit of `wr_strobe` pulses for exactly one cycle.
- R3: After a command byte with bit 7 = 1, a repeated start and the read address return that register's value, most significant bit first.
- R4: Command 00h followed by a count byte and then data bytes stores the data at registers 0, 1, 2 and upward. Every byte is acknowledged.
- R5: A block read (command 00h, repeated start, read address) returns 15 first, then registers 0, 1, 2 and upward, for as long as the master acknowledges.
- R6: After reset the registers hold these values: index 1 = 7Fh, 3 = FFh, 4 = 47h, 5 = DFh, 6 = 03h, 8 = 60h, 9 = 1Ch, 10 = 0Fh, index 0 = 40h with its low five bits taken from the strap input, index 7 = 48h, and all others 00h.
- R7: Bits 4:0 of register 0 always show the `strap_fs` input, and register 7 always reads 48h. Writes change only bits 7:5 of register 0 and nothing in register 7.
- R8: A write to offset 15 or above is acknowledged, changes no register and pulses no strobe. A read from such an offset returns 00h.
- R9: A start or stop condition in the middle of a byte abandons that byte without storing it. After a start the slave is ready to match an address again.
- R10: A master may end a block write with a stop after any complete byte. Registers past the last byte sent keep their values.
- R11: The slave only starts pulling SDA low in a cycle that follows a cycle in which SCL was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| strap_fs | input | 5 | Latched frequency-select straps shown in register 0 |
| sda_drive_low | output | 1 | When 1, the SDA pad is pulled low |
| regs_o | output | 120 | Register values, register i at bits [8i+7:8i] |
| wr_strobe | output | 15 | One-cycle pulse per register written |

## Verification
Every response is timed from a sampled SCL falling edge. At the first clock edge after SCL is seen low, the acknowledge drive, the next transmitted bit, the register update and the write strobe all register together. They are therefore visible one cycle after the edge at which the fall is first sampled. The bench holds each SCL half-period for eight clocks and changes inputs just after a clock edge. It reads acknowledges and returned data late in the SCL high phase, and checks registers several cycles after the ninth clock of a byte, well after that single-cycle latency. Strobes are counted on every cycle, so the number of strobes per transfer is checked exactly.

// File: rtl/smbc_pkg.sv
package smbc_pkg;
  localparam int unsigned REG_COUNT = 15;
  localparam int unsigned OFF_W     = 7;
  localparam logic [6:0]  DEV_ADDR  = 7'h69;
  localparam logic [7:0]  ID_VALUE  = 8'h48;
  localparam int unsigned STRAP_REG = 0;
  localparam int unsigned ID_REG    = 7;
  localparam int unsigned STRAP_W   = 5;

  typedef enum logic [2:0] {PH_IDLE, PH_RECV, PH_ACK_OUT, PH_SEND, PH_ACK_IN} phase_t;
  typedef enum logic [1:0] {BK_ADDR, BK_CMD, BK_COUNT, BK_DATA} bkind_t;

  // Value each register takes at reset (read-only bits are overlaid later).
  function automatic logic [7:0] reg_default(input int unsigned idx);
    case (idx)
      0:       return 8'h40;
      1:       return 8'h7F;
      3:       return 8'hFF;
      4:       return 8'h47;
      5:       return 8'hDF;
      6:       return 8'h03;
      8:       return 8'h60;
      9:       return 8'h1C;
      10:      return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  // Bits a host may change.
  function automatic logic [7:0] wr_mask(input int unsigned idx);
    if (idx == STRAP_REG) return 8'hE0;
    if (idx == ID_REG)    return 8'h00;
    return 8'hFF;
  endfunction

  // Read-only contribution to a register's visible value.
  function automatic logic [7:0] ro_bits(input int unsigned idx, input logic [STRAP_W-1:0] strap);
    if (idx == STRAP_REG) return {{(8-STRAP_W){1'b0}}, strap};
    if (idx == ID_REG)    return ID_VALUE;
    return 8'h00;
  endfunction
endpackage

// File: rtl/smbc_line_events.sv
module smbc_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smbc_regbank.sv
module smbc_regbank
  import smbc_pkg::*;
#(
  parameter int unsigned NREG = REG_COUNT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [OFF_W-1:0]     wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [OFF_W-1:0]     rd_idx,
  input  logic [STRAP_W-1:0]   strap,
  output logic [7:0]           rd_data,
  output logic [NREG*8-1:0]    regs_o,
  output logic [NREG-1:0]      wr_strobe
);
  logic [7:0] view [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] MASK = wr_mask(g);
    logic [7:0] store;
    wire hit = wr_en && (wr_idx == OFF_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store        <= reg_default(g);
        wr_strobe[g] <= 1'b0;
      end else begin
        wr_strobe[g] <= hit;
        if (hit) store <= (store & ~MASK) | (wr_data & MASK);
      end
    end

    assign view[g] = (store & MASK) | ro_bits(g, strap);
    assign regs_o[g*8 +: 8] = view[g];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < int'(NREG); i++)
      if (rd_idx == OFF_W'(i)) rd_data = view[i];
  end

  // R2: at most one register strobed per cycle
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobe));
  // R8: writes past the bank leave every strobe low
  a_r8_no_strobe_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= OFF_W'(NREG))) |=> (wr_strobe == '0));
endmodule

// File: rtl/smbc_reg_slave.sv
module smbc_reg_slave
  import smbc_pkg::*;
#(
  parameter int unsigned NREG  = REG_COUNT,
  parameter logic [6:0]  ADDR7 = DEV_ADDR
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [STRAP_W-1:0]   strap_fs,
  output logic                 sda_drive_low,
  output logic [NREG*8-1:0]    regs_o,
  output logic [NREG-1:0]      wr_strobe
);
  localparam logic [OFF_W-1:0] PTR_TOP = '1;
  localparam logic [7:0]       COUNT_BYTE = 8'(NREG);

  logic scl_rise, scl_fall, start_ev, stop_ev;
  phase_t ph;
  bkind_t kind;
  logic [3:0] bitc;
  logic [7:0] shreg;
  logic rd_mode, blk_mode, count_due, mack, sda_low;
  logic [OFF_W-1:0] ptr;
  logic [7:0] rd_data;

  smbc_line_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  wire byte_done = (ph == PH_RECV) && scl_fall && (bitc == 4'd8);
  wire addr_hit  = (shreg[7:1] == ADDR7);
  wire wr_en     = byte_done && (kind == BK_DATA) && !rd_mode;
  wire [7:0] tx_byte = count_due ? COUNT_BYTE : rd_data;

  smbc_regbank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr), .wr_data(shreg),
    .rd_idx(ptr), .strap(strap_fs), .rd_data(rd_data), .regs_o(regs_o),
    .wr_strobe(wr_strobe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; kind <= BK_ADDR; bitc <= 4'd0; shreg <= 8'h00;
      rd_mode <= 1'b0; blk_mode <= 1'b0; count_due <= 1'b0; mack <= 1'b0;
      ptr <= '0; sda_low <= 1'b0;
    end else if (start_ev) begin
      ph <= PH_RECV; kind <= BK_ADDR; bitc <= 4'd0; sda_low <= 1'b0; rd_mode <= 1'b0;
    end else if (stop_ev) begin
      ph <= PH_IDLE; sda_low <= 1'b0;
    end else begin
      case (ph)
        PH_RECV: begin
          if (scl_rise && bitc < 4'd8) begin
            shreg <= {shreg[6:0], sda_i};
            bitc  <= bitc + 4'd1;
          end else if (byte_done) begin
            ph <= PH_ACK_OUT;
            sda_low <= 1'b1;
            case (kind)
              BK_ADDR: begin
                if (!addr_hit) begin
                  ph <= PH_IDLE;
                  sda_low <= 1'b0;
                end else begin
                  rd_mode   <= shreg[0];
                  count_due <= shreg[0] & blk_mode;
                  kind      <= BK_CMD;
                end
              end
              BK_CMD: begin
                blk_mode <= ~shreg[7];
                ptr      <= shreg[7] ? shreg[6:0] : '0;
                kind     <= shreg[7] ? BK_DATA : BK_COUNT;
              end
              BK_COUNT: kind <= BK_DATA;
              default:  if (ptr != PTR_TOP) ptr <= ptr + 1'b1;
            endcase
          end
        end
        PH_ACK_OUT: begin
          if (scl_fall) begin
            bitc <= 4'd0;
            if (rd_mode) begin
              ph <= PH_SEND;
              shreg <= tx_byte;
              sda_low <= ~tx_byte[7];
              if (count_due) count_due <= 1'b0;
              else if (ptr != PTR_TOP) ptr <= ptr + 1'b1;
            end else begin
              ph <= PH_RECV;
              sda_low <= 1'b0;
            end
          end
        end
        PH_SEND: begin
          if (scl_fall) begin
            if (bitc == 4'd7) begin
              ph <= PH_ACK_IN;
              sda_low <= 1'b0;
            end else begin
              bitc <= bitc + 4'd1;
              shreg <= {shreg[6:0], 1'b0};
              sda_low <= ~shreg[6];
            end
          end
        end
        PH_ACK_IN: begin
          if (scl_rise) mack <= ~sda_i;
          else if (scl_fall) begin
            if (mack) begin
              ph <= PH_SEND;
              bitc <= 4'd0;
              shreg <= tx_byte;
              sda_low <= ~tx_byte[7];
              if (count_due) count_due <= 1'b0;
              else if (ptr != PTR_TOP) ptr <= ptr + 1'b1;
            end else begin
              ph <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_drive_low = sda_low;

  // R11: pull-low only begins after SCL was sampled low
  a_r11_drive_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> !$past(scl_i));
  // R1: a foreign address is never acknowledged
  a_r1_foreign_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && kind == BK_ADDR && !addr_hit) |=> !sda_drive_low);
  // R9: a start always restarts address reception cleanly
  a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (ph == PH_RECV && kind == BK_ADDR && bitc == 4'd0 && !sda_drive_low));
  // R2: a strobe only follows a sampled SCL fall
  a_r2_strobe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_strobe) |-> $past(scl_fall));
  // R9: the bit counter never runs past one byte
  a_r9_bitc_range: assert property (@(posedge clk) disable iff (!rst_n)
    bitc <= 4'd8);
endmodule

// File: tb/tb_smbc_reg_slave.sv
module tb_smbc_reg_slave;
  localparam int NREG = 15;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [4:0] strap = 5'h15;
  logic sda_drive_low;
  logic [NREG*8-1:0] regs;
  logic [NREG-1:0] stb;
  wire sda_bus = sda_m & ~sda_drive_low;

  int n_total = 0;
  int n_bad = 0;
  int stb_cnt = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smbc_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_fs(strap),
    .sda_drive_low(sda_drive_low), .regs_o(regs), .wr_strobe(stb)
  );

  always @(posedge clk) if (rst_n) stb_cnt <= stb_cnt + $countones(stb);

  // offset, write data, expected readback (strap = 15h)
  localparam logic [23:0] VEC [6] = '{
    24'h03_A5_A5,   // R2 R3 plain register
    24'h08_3C_3C,   // R2 R3
    24'h00_FF_F5,   // R7 only bits 7:5 writable, low bits = strap
    24'h07_00_48,   // R7 id register fixed
    24'h14_55_00,   // R8 offset 20 outside bank
    24'h0E_81_81    // R2 R3 last register
  };

  function automatic logic [7:0] exp_reset(input int i);
    logic [7:0] t [NREG] = '{8'h55, 8'h7F, 8'h00, 8'hFF, 8'h47, 8'hDF, 8'h03,
                             8'h48, 8'h60, 8'h1C, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00};
    return t[i];
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_total++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = ~sda_bus;
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
      b[i] = sda_bus;
      scl = 1'b0; tick(Q);
    end
    sda_m = ~give_ack; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic byte_write(input string tag, input logic [7:0] off, input logic [7:0] d);
    logic a;
    bus_start();
    send_byte(8'hD2, a); chk({tag, " R1 addr ack"}, 8'(a), 8'h01);
    send_byte(8'h80 | off, a); chk({tag, " R2 cmd ack"}, 8'(a), 8'h01);
    send_byte(d, a); chk({tag, " R2 data ack"}, 8'(a), 8'h01);
    bus_stop();
  endtask

  task automatic byte_read(input logic [7:0] off, output logic [7:0] d);
    logic a;
    bus_start();
    send_byte(8'hD2, a); chk("R3 addr ack", 8'(a), 8'h01);
    send_byte(8'h80 | off, a); chk("R3 cmd ack", 8'(a), 8'h01);
    bus_start();
    send_byte(8'hD3, a); chk("R1 read addr ack", 8'(a), 8'h01);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  function automatic logic [7:0] reg_at(input int i);
    return regs[i*8 +: 8];
  endfunction

  initial begin
    logic a;
    logic [7:0] d;
    int s0;
    tick(4);
    // R6 reset state
    for (int i = 0; i < NREG; i++) chk($sformatf("R6 reset reg%0d", i), reg_at(i), exp_reset(i));
    chk("R11 idle no drive", 8'(sda_drive_low), 8'h00);
    rst_n = 1'b1;
    tick(4);
    chk("R6 no strobe after reset", 8'(stb_cnt), 8'h00);

    // vector table: byte write then byte read back
    foreach (VEC[k]) begin
      s0 = stb_cnt;
      byte_write("vec", VEC[k][23:16], VEC[k][15:8]);
      chk($sformatf("R2 R8 strobes off %0h", VEC[k][23:16]), 8'(stb_cnt - s0),
          (VEC[k][23:16] < 8'(NREG)) ? 8'h01 : 8'h00);
      byte_read(VEC[k][23:16], d);
      chk($sformatf("R3 R7 R8 readback off %0h", VEC[k][23:16]), d, VEC[k][7:0]);
    end
    chk("R7 id reg parallel", reg_at(7), 8'h48);

    // R1 foreign address
    s0 = stb_cnt;
    bus_start();
    send_byte(8'hA4, a); chk("R1 foreign addr nack", 8'(a), 8'h00);
    send_byte(8'h83, a); chk("R1 foreign cmd nack", 8'(a), 8'h00);
    send_byte(8'h00, a);
    bus_stop();
    chk("R1 foreign no write", reg_at(3), 8'hA5);
    chk("R1 foreign no strobe", 8'(stb_cnt - s0), 8'h00);

    // R4 block write of three bytes
    s0 = stb_cnt;
    bus_start();
    send_byte(8'hD2, a); chk("R4 addr ack", 8'(a), 8'h01);
    send_byte(8'h00, a); chk("R4 cmd ack", 8'(a), 8'h01);
    send_byte(8'h03, a); chk("R4 count ack", 8'(a), 8'h01);
    send_byte(8'h11, a); chk("R4 data0 ack", 8'(a), 8'h01);
    send_byte(8'h22, a); chk("R4 data1 ack", 8'(a), 8'h01);
    send_byte(8'h33, a); chk("R4 data2 ack", 8'(a), 8'h01);
    bus_stop();
    chk("R4 R7 reg0", reg_at(0), 8'h15);
    chk("R4 reg1", reg_at(1), 8'h22);
    chk("R4 reg2", reg_at(2), 8'h33);
    chk("R4 reg3 untouched", reg_at(3), 8'hA5);
    chk("R4 strobe count", 8'(stb_cnt - s0), 8'h03);

    // R5 block read: count then regs 0..3
    bus_start();
    send_byte(8'hD2, a); chk("R5 addr ack", 8'(a), 8'h01);
    send_byte(8'h00, a); chk("R5 cmd ack", 8'(a), 8'h01);
    bus_start();
    send_byte(8'hD3, a); chk("R5 read addr ack", 8'(a), 8'h01);
    recv_byte(1'b1, d); chk("R5 count", d, 8'd15);
    recv_byte(1'b1, d); chk("R5 reg0", d, 8'h15);
    recv_byte(1'b1, d); chk("R5 reg1", d, 8'h22);
    recv_byte(1'b1, d); chk("R5 reg2", d, 8'h33);
    recv_byte(1'b0, d); chk("R5 reg3", d, 8'hA5);
    bus_stop();
    chk("R5 released after nack", 8'(sda_drive_low), 8'h00);

    // R10 block write stopped after one data byte
    s0 = stb_cnt;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h05, a);
    send_byte(8'h66, a); chk("R10 data ack", 8'(a), 8'h01);
    bus_stop();
    chk("R10 reg0", reg_at(0), 8'h75);
    chk("R10 reg1 kept", reg_at(1), 8'h22);
    chk("R10 strobe count", 8'(stb_cnt - s0), 8'h01);

    // R9 stop in the middle of a data byte
    s0 = stb_cnt;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h82, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    chk("R9 stop mid byte no write", reg_at(2), 8'h33);
    chk("R9 stop mid byte no strobe", 8'(stb_cnt - s0), 8'h00);

    // R9 start in the middle of a command byte, then a full write
    bus_start();
    send_byte(8'hD2, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    bus_start();
    send_byte(8'hD2, a); chk("R9 addr after restart", 8'(a), 8'h01);
    send_byte(8'h83, a); send_byte(8'h99, a); chk("R9 data after restart", 8'(a), 8'h01);
    bus_stop();
    chk("R9 write after restart", reg_at(3), 8'h99);

    // R7 strap bits track the input
    strap = 5'h0A;
    tick(2);
    chk("R7 strap follows input", reg_at(0), 8'h6A);
    byte_read(8'h00, d);
    chk("R7 strap readback", d, 8'h6A);

    summary();
  end
endmodule